// File: doc/BRIEF.md
# Vector-Length-Controlled Integer Arithmetic Unit

This unit runs one element-wise integer operation over a vector held in an external vector register file. An operation is either an add or a multiply, and its first operand is either a second vector or one scalar value that is applied to every element. The number of elements an operation touches comes from a programmable length register. The length can be anything from zero up to the register capacity.

On an accepted start pulse the unit latches the opcode, the register indices, the scalar and the current length. It then issues one element read per clock on two read ports that share an index. The returned operands stream through a fixed three-stage pipeline, and the results leave on one write port in index order. A single-cycle done pulse follows the last write. A zero-length operation reads and writes nothing and signals done on the next cycle. Destination elements at or above the length are never written, so they keep their old contents.

Top module: `vlen_arith_unit`

## Requirements
- R1: The length register resets to MAX_VL. A `len_we` pulse loads `len_wdata`, and a value above MAX_VL is stored as MAX_VL. Without `len_we` the register holds its value. A start in the same cycle as a length write uses the old length.
- R2: Opcode encoding is: 2'b00 is vector+vector add, 2'b01 is scalar+vector add, 2'b10 is vector×vector multiply, 2'b11 is scalar×vector multiply. Bit 1 selects multiply and bit 0 selects the scalar form. Results are the low ELEM_W bits, two's complement, and wrap on overflow.
- R3: In the scalar forms the `scalar` value sampled at start replaces the port-A operand for every element. The port-B element comes from register `src_b`.
- R4: When a start is accepted in cycle s, `rd_en` is high in cycles s+1 to s+L, where L is the latched length. In cycle s+1+i it shows `rd_idx`=i, `rd_reg_a`=`src_a` and `rd_reg_b`=`src_b`. Read data is expected one cycle after the request.
- R5: Element i is written in cycle s+5+i with `wr_reg`=`dst` and `wr_idx`=i. Exactly L writes occur, and no index at or above L is written, so those destination elements keep their contents.
- R6: `done` pulses for one cycle in cycle s+5+L. When L=0 it pulses in cycle s+1 and no read or write happens.
- R7: `busy` is high in cycles s+1 to s+4+L and low otherwise. A start is accepted only while `busy` is low, including the done cycle. A start while busy has no effect.
- R8: The length is latched at start. Length writes during an operation change only later operations.
- R9: While reset is held and after it, `busy`, `done`, `rd_en` and `wr_en` are low until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_we | input | 1 | Load the length register |
| len_wdata | input | VLW | New length value (clamped to MAX_VL) |
| start | input | 1 | Launch an operation |
| opcode | input | 2 | Operation select |
| dst | input | RW | Destination vector register |
| src_a | input | RW | First source vector register |
| src_b | input | RW | Second source vector register |
| scalar | input | ELEM_W | Broadcast operand for the scalar forms |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Element read request |
| rd_reg_a | output | RW | Register index on read port A |
| rd_reg_b | output | RW | Register index on read port B |
| rd_idx | output | IDXW | Element index for both read ports |
| rd_data_a | input | ELEM_W | Port A element, one cycle after the request |
| rd_data_b | input | ELEM_W | Port B element, one cycle after the request |
| wr_en | output | 1 | Element write enable |
| wr_reg | output | RW | Destination register index |
| wr_idx | output | IDXW | Destination element index |
| wr_data | output | ELEM_W | Result element |

## Verification
The bench builds the unit with its defaults: ELEM_W=32, MAX_VL=64 and NREGS=8. A 64-element operation therefore spans the full index range, and 32-bit products from mixed-bit patterns wrap. Because the 7-bit length input can carry values above 64, the clamp can be driven with 100. The lengths 0, 1, 5, 10, 63 and 64 cover the empty, single-element, short and full cases. The in-place case, where the destination equals a source, is also run, as are starts issued at the done cycle and starts issued while busy.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

    typedef enum logic [1:0] {
        VOP_ADD_VV = 2'b00,
        VOP_ADD_SV = 2'b01,
        VOP_MUL_VV = 2'b10,
        VOP_MUL_SV = 2'b11
    } vop_e;

    function automatic logic op_is_scalar(vop_e op);
        return op[0];
    endfunction

    function automatic logic op_is_mul(vop_e op);
        return op[1];
    endfunction

    function automatic int unsigned clamp_len(int unsigned req, int unsigned maxv);
        return (req > maxv) ? maxv : req;
    endfunction

endpackage

// File: rtl/vlen_len_reg.sv
module vlen_len_reg #(
    parameter int MAX_VL = 64,
    parameter int VLW    = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [VLW-1:0] wdata,
    output logic [VLW-1:0] len_q
);
    import vlen_pkg::*;

    logic [VLW-1:0] len_next;

    always_comb begin
        len_next = VLW'(clamp_len(int'(wdata), MAX_VL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= VLW'(MAX_VL);
        end else if (we) begin
            len_q <= len_next;
        end
    end

    // R1: without a write the length holds
    a_r1_len_holds: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(len_q));

endmodule

// File: rtl/vlen_sequencer.sv
module vlen_sequencer #(
    parameter int VLW    = 7,
    parameter int IDXW   = 6,
    parameter int RW     = 3,
    parameter int ELEM_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  vlen_pkg::vop_e    op_in,
    input  logic [RW-1:0]     dst_in,
    input  logic [RW-1:0]     src_a_in,
    input  logic [RW-1:0]     src_b_in,
    input  logic [ELEM_W-1:0] scalar_in,
    input  logic [VLW-1:0]    len_in,
    output logic              active,
    output logic              iss_last,
    output logic [IDXW-1:0]   iss_idx,
    output vlen_pkg::vop_e    op_q,
    output logic [RW-1:0]     dst_q,
    output logic [RW-1:0]     src_a_q,
    output logic [RW-1:0]     src_b_q,
    output logic [ELEM_W-1:0] scalar_q,
    output logic [VLW-1:0]    len_op
);
    import vlen_pkg::*;

    logic [IDXW-1:0] cnt;

    always_comb begin
        iss_idx  = cnt;
        iss_last = active && ((VLW'(cnt) + VLW'(1)) == len_op);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cnt      <= '0;
            len_op   <= '0;
            op_q     <= VOP_ADD_VV;
            dst_q    <= '0;
            src_a_q  <= '0;
            src_b_q  <= '0;
            scalar_q <= '0;
        end else if (accept) begin
            active   <= (len_in != '0);
            cnt      <= '0;
            len_op   <= len_in;
            op_q     <= op_in;
            dst_q    <= dst_in;
            src_a_q  <= src_a_in;
            src_b_q  <= src_b_in;
            scalar_q <= scalar_in;
        end else if (active) begin
            cnt <= cnt + IDXW'(1);
            if (iss_last) begin
                active <= 1'b0;
            end
        end
    end

    // R4: consecutive issue cycles step the element index by one
    a_r4_idx_steps: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> (iss_idx == IDXW'($past(iss_idx) + IDXW'(1))));

    // R8: latched length never changes during an operation
    a_r8_len_latched: assert property (@(posedge clk) disable iff (rst)
        (active && !accept) |=> $stable(len_op));

endmodule

// File: rtl/vlen_pipe.sv
module vlen_pipe #(
    parameter int ELEM_W = 32,
    parameter int IDXW   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_en,
    input  logic              iss_last,
    input  logic [IDXW-1:0]   iss_idx,
    input  vlen_pkg::vop_e    iss_op,
    input  logic [ELEM_W-1:0] scalar_q,
    input  logic [ELEM_W-1:0] rd_data_a,
    input  logic [ELEM_W-1:0] rd_data_b,
    output logic              pipe_busy,
    output logic              out_valid,
    output logic              out_last,
    output logic [IDXW-1:0]   out_idx,
    output logic [ELEM_W-1:0] out_data
);
    import vlen_pkg::*;

    typedef struct packed {
        logic            valid;
        logic            last;
        logic [IDXW-1:0] idx;
        vop_e            op;
    } meta_t;

    typedef struct packed {
        meta_t             m;
        logic [ELEM_W-1:0] a;
        logic [ELEM_W-1:0] b;
    } opnd_t;

    typedef struct packed {
        meta_t             m;
        logic [ELEM_W-1:0] r;
    } res_t;

    meta_t ret_q;
    opnd_t s1_q;
    res_t  s2_q;
    res_t  s3_q;

    logic [ELEM_W-1:0] op_a;
    logic [ELEM_W-1:0] sum;
    logic [ELEM_W-1:0] prod;

    always_comb begin
        op_a = op_is_scalar(ret_q.op) ? scalar_q : rd_data_a;
        sum  = s1_q.a + s1_q.b;
        prod = s1_q.a * s1_q.b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_q <= '0;
            s1_q  <= '0;
            s2_q  <= '0;
            s3_q  <= '0;
        end else begin
            ret_q.valid <= iss_en;
            ret_q.last  <= iss_last;
            ret_q.idx   <= iss_idx;
            ret_q.op    <= iss_op;

            s1_q.m <= ret_q;
            s1_q.a <= op_a;
            s1_q.b <= rd_data_b;

            s2_q.m <= s1_q.m;
            s2_q.r <= op_is_mul(s1_q.m.op) ? prod : sum;

            s3_q <= s2_q;
        end
    end

    always_comb begin
        pipe_busy = ret_q.valid | s1_q.m.valid | s2_q.m.valid | s3_q.m.valid;
        out_valid = s3_q.m.valid;
        out_last  = s3_q.m.valid & s3_q.m.last;
        out_idx   = s3_q.m.idx;
        out_data  = s3_q.r;
    end

    // R5: write-back leaves in increasing index order
    a_r5_wr_order: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_idx == IDXW'($past(out_idx) + IDXW'(1))));

    // R4: an issued element reaches write-back three stages after its data returns
    a_r4_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        ret_q.valid |=> s1_q.m.valid);

endmodule

// File: rtl/vlen_arith_unit.sv
module vlen_arith_unit #(
    parameter int ELEM_W = 32,
    parameter int MAX_VL = 64,
    parameter int NREGS  = 8,
    localparam int VLW   = $clog2(MAX_VL + 1),
    localparam int IDXW  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
    localparam int RW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              len_we,
    input  logic [VLW-1:0]    len_wdata,
    input  logic              start,
    input  logic [1:0]        opcode,
    input  logic [RW-1:0]     dst,
    input  logic [RW-1:0]     src_a,
    input  logic [RW-1:0]     src_b,
    input  logic [ELEM_W-1:0] scalar,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [RW-1:0]     rd_reg_a,
    output logic [RW-1:0]     rd_reg_b,
    output logic [IDXW-1:0]   rd_idx,
    input  logic [ELEM_W-1:0] rd_data_a,
    input  logic [ELEM_W-1:0] rd_data_b,
    output logic              wr_en,
    output logic [RW-1:0]     wr_reg,
    output logic [IDXW-1:0]   wr_idx,
    output logic [ELEM_W-1:0] wr_data
);
    import vlen_pkg::*;

    logic [VLW-1:0]    len_cur;
    logic [VLW-1:0]    len_op;
    logic              accept;
    logic              seq_active;
    logic              iss_last;
    logic [IDXW-1:0]   iss_idx;
    vop_e              op_q;
    logic [RW-1:0]     dst_q;
    logic [RW-1:0]     src_a_q;
    logic [RW-1:0]     src_b_q;
    logic [ELEM_W-1:0] scalar_q;
    logic              pipe_busy;
    logic              out_last;
    logic              done_q;

    vlen_len_reg #(.MAX_VL(MAX_VL), .VLW(VLW)) u_len (
        .clk   (clk),
        .rst   (rst),
        .we    (len_we),
        .wdata (len_wdata),
        .len_q (len_cur)
    );

    vlen_sequencer #(.VLW(VLW), .IDXW(IDXW), .RW(RW), .ELEM_W(ELEM_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .op_in     (vop_e'(opcode)),
        .dst_in    (dst),
        .src_a_in  (src_a),
        .src_b_in  (src_b),
        .scalar_in (scalar),
        .len_in    (len_cur),
        .active    (seq_active),
        .iss_last  (iss_last),
        .iss_idx   (iss_idx),
        .op_q      (op_q),
        .dst_q     (dst_q),
        .src_a_q   (src_a_q),
        .src_b_q   (src_b_q),
        .scalar_q  (scalar_q),
        .len_op    (len_op)
    );

    vlen_pipe #(.ELEM_W(ELEM_W), .IDXW(IDXW)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .iss_en    (seq_active),
        .iss_last  (iss_last),
        .iss_idx   (iss_idx),
        .iss_op    (op_q),
        .scalar_q  (scalar_q),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b),
        .pipe_busy (pipe_busy),
        .out_valid (wr_en),
        .out_last  (out_last),
        .out_idx   (wr_idx),
        .out_data  (wr_data)
    );

    always_comb begin
        busy     = seq_active | pipe_busy;
        accept   = start & ~busy;
        rd_en    = seq_active;
        rd_idx   = iss_idx;
        rd_reg_a = src_a_q;
        rd_reg_b = src_b_q;
        wr_reg   = dst_q;
        done     = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= out_last | (accept & (len_cur == '0));
        end
    end

    // R5: no write at or beyond the latched length
    a_r5_wr_below_len: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (VLW'(wr_idx) < len_op));

    // R6: done follows either the final write or a zero-length start
    a_r6_done_cause: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_en) || $past(start && !busy)));

    // R6: done never coincides with a write
    a_r6_done_alone: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en);

    // R7: an idle unit neither reads nor writes
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rd_en && !wr_en));

endmodule

// File: tb/vlen_arith_unit_tb.sv
module vlen_arith_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ELEM_W     = 32;
    localparam int MAX_VL     = 64;
    localparam int NREGS      = 8;
    localparam int VLW        = $clog2(MAX_VL + 1);
    localparam int IDXW       = $clog2(MAX_VL);
    localparam int RW         = $clog2(NREGS);
    localparam int WDOG       = 200000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              len_we = 1'b0;
    logic [VLW-1:0]    len_wdata = '0;
    logic              start = 1'b0;
    logic [1:0]        opcode = '0;
    logic [RW-1:0]     dst = '0, src_a = '0, src_b = '0;
    logic [ELEM_W-1:0] scalar = '0;
    logic              busy, done, rd_en, wr_en;
    logic [RW-1:0]     rd_reg_a, rd_reg_b, wr_reg;
    logic [IDXW-1:0]   rd_idx, wr_idx;
    logic [ELEM_W-1:0] rd_data_a = '0, rd_data_b = '0, wr_data;

    vlen_arith_unit #(.ELEM_W(ELEM_W), .MAX_VL(MAX_VL), .NREGS(NREGS)) dut_i (
        .clk(clk), .rst(rst), .len_we(len_we), .len_wdata(len_wdata),
        .start(start), .opcode(opcode), .dst(dst), .src_a(src_a), .src_b(src_b),
        .scalar(scalar), .busy(busy), .done(done), .rd_en(rd_en),
        .rd_reg_a(rd_reg_a), .rd_reg_b(rd_reg_b), .rd_idx(rd_idx),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .wr_en(wr_en),
        .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // register file environment: one-cycle read, write at the edge
    logic [ELEM_W-1:0] rf   [NREGS][MAX_VL];
    logic [ELEM_W-1:0] rmod [NREGS][MAX_VL];

    always @(posedge clk) begin
        if (rd_en === 1'b1) begin
            rd_data_a <= rf[rd_reg_a][rd_idx];
            rd_data_b <= rf[rd_reg_b][rd_idx];
        end
        if (wr_en === 1'b1) begin
            rf[wr_reg][wr_idx] <= wr_data;
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int cyc; int idx; int ra; int rb; } rd_exp_t;
    typedef struct { int cyc; int rg; int idx; logic [ELEM_W-1:0] data; } wr_exp_t;

    rd_exp_t rdq[$];
    wr_exp_t wrq[$];
    int      doneq[$];

    int  n_cmp = 0;
    int  n_bad = 0;
    int  len_m = MAX_VL;
    int  busy_from = 1;
    int  busy_to = 0;
    bit  checking = 0;
    bit  finished = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: act=%0h exp=%0h", req, what, cyc, act, exp);
        end
    endtask

    function automatic bit m_busy(int c);
        return (c >= busy_from) && (c <= busy_to);
    endfunction

    // per-cycle comparison against the behavioural expectation queues
    always @(negedge clk) begin
        if (checking && !finished) begin
            bit e_rd, e_wr, e_dn;
            e_rd = (rdq.size() > 0) && (rdq[0].cyc == cyc);
            e_wr = (wrq.size() > 0) && (wrq[0].cyc == cyc);
            e_dn = (doneq.size() > 0) && (doneq[0] == cyc);
            check(rd_en === e_rd, "R4", "rd_en", longint'(rd_en), longint'(e_rd));
            if (e_rd) begin
                check(rd_idx === IDXW'(rdq[0].idx), "R4", "rd_idx", longint'(rd_idx), longint'(rdq[0].idx));
                check(rd_reg_a === RW'(rdq[0].ra), "R4", "rd_reg_a", longint'(rd_reg_a), longint'(rdq[0].ra));
                check(rd_reg_b === RW'(rdq[0].rb), "R4", "rd_reg_b", longint'(rd_reg_b), longint'(rdq[0].rb));
                void'(rdq.pop_front());
            end
            check(wr_en === e_wr, "R5", "wr_en", longint'(wr_en), longint'(e_wr));
            if (e_wr) begin
                check(wr_idx === IDXW'(wrq[0].idx), "R5", "wr_idx", longint'(wr_idx), longint'(wrq[0].idx));
                check(wr_reg === RW'(wrq[0].rg), "R5", "wr_reg", longint'(wr_reg), longint'(wrq[0].rg));
                check(wr_data === wrq[0].data, "R2", "wr_data", longint'(wr_data), longint'(wrq[0].data));
                void'(wrq.pop_front());
            end
            check(done === e_dn, "R6", "done", longint'(done), longint'(e_dn));
            if (e_dn) void'(doneq.pop_front());
            check(busy === m_busy(cyc), "R7", "busy", longint'(busy), longint'(m_busy(cyc)));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    // R1: model of the length register with clamp
    task automatic set_len(int v);
        len_we    = 1'b1;
        len_wdata = VLW'(v);
        tick();
        len_we = 1'b0;
        len_m  = (v > MAX_VL) ? MAX_VL : v;
    endtask

    task automatic start_op(int op, int d, int sa, int sb, logic [ELEM_W-1:0] sc);
        int s;
        s      = cyc;
        start  = 1'b1;
        opcode = 2'(op);
        dst    = RW'(d);
        src_a  = RW'(sa);
        src_b  = RW'(sb);
        scalar = sc;
        if (!m_busy(s)) begin
            for (int i = 0; i < len_m; i++) begin
                logic [ELEM_W-1:0] a, b, r;
                a = ((op & 1) != 0) ? sc : rmod[sa][i];   // R3 broadcast
                b = rmod[sb][i];
                r = ((op & 2) != 0) ? a * b : a + b;       // R2 low bits
                rdq.push_back('{s + 1 + i, i, sa, sb});
                wrq.push_back('{s + 5 + i, d, i, r});
                rmod[d][i] = r;
            end
            doneq.push_back((len_m == 0) ? s + 1 : s + 5 + len_m);
            busy_from = s + 1;
            busy_to   = (len_m == 0) ? s : s + 4 + len_m;
        end
        tick();
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy(cyc)) tick();
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d: act=running exp=finished", cyc);
        report();
    end

    initial begin
        for (int r = 0; r < NREGS; r++)
            for (int i = 0; i < MAX_VL; i++) begin
                rf[r][i]   = (32'(r) * 32'h0101_0101) ^ (32'(i) * 32'h9E37_79B1) ^ 32'h0000_0F0F;
                rmod[r][i] = rf[r][i];
            end
        repeat (4) tick();
        // R9: outputs quiet during reset
        check(busy === 1'b0 && done === 1'b0, "R9", "busy/done in reset", {busy, done}, 0);
        check(rd_en === 1'b0 && wr_en === 1'b0, "R9", "rd/wr in reset", {rd_en, wr_en}, 0);
        rst = 1'b0;
        tick();
        checking = 1;
        tick();
        check(busy === 1'b0 && done === 1'b0 && rd_en === 1'b0 && wr_en === 1'b0,
              "R9", "idle after reset", {busy, done, rd_en, wr_en}, 0);

        // R1 reset length is MAX_VL; R2 vector add full length
        start_op(0, 3, 1, 2, 32'h0);
        wait_idle();
        // R3 scalar add, negative scalar, short length
        set_len(10);
        start_op(1, 4, 0, 2, 32'hFFFF_FFF9);
        wait_idle();
        // R2 vector multiply with wrap
        set_len(5);
        start_op(2, 5, 6, 7, 32'h0);
        wait_idle();
        // R3 scalar multiply, full length, large scalar
        set_len(64);
        start_op(3, 6, 0, 1, 32'h8000_0001);
        wait_idle();
        // R6 zero length, then an immediate follow-on start
        set_len(0);
        start_op(0, 7, 1, 2, 32'h0);
        set_len(1);
        start_op(2, 7, 3, 3, 32'h0);
        wait_idle();
        // R1 clamp of an oversize length
        set_len(100);
        start_op(1, 2, 0, 5, 32'h0000_0003);
        // R7 start while busy is ignored
        tick();
        tick();
        start_op(3, 1, 1, 1, 32'h1234_5678);
        wait_idle();
        // R8 length written mid-operation applies only afterwards
        set_len(8);
        start_op(0, 0, 4, 5, 32'h0);
        tick();
        set_len(3);
        wait_idle();
        // in-place: destination equals a source, back-to-back at done
        start_op(2, 4, 4, 4, 32'h0);
        wait_idle();
        set_len(63);
        start_op(1, 4, 0, 4, 32'h0000_0010);
        wait_idle();
        repeat (8) tick();
        check(rdq.size() == 0 && wrq.size() == 0 && doneq.size() == 0,
              "R5", "pending expectations", rdq.size() + wrq.size() + doneq.size(), 0);
        // R5 final contents: untouched elements retained, results in place
        for (int r = 0; r < NREGS; r++)
            for (int i = 0; i < MAX_VL; i++)
                check(rf[r][i] === rmod[r][i], "R5", $sformatf("rf[%0d][%0d]", r, i),
                      longint'(rf[r][i]), longint'(rmod[r][i]));
        report();
    end

endmodule